// File: doc/BRIEF.md
# Mirrored Coefficient Table Packer

This block turns a half-table of polyphase filter coefficients into the full register image that a scaler's filter bank expects. The source table holds 9 stored phases of 7 taps each, every tap a 12-bit two's-complement value. The block walks 16 output phases. Phases 0 to 8 come straight from the table. Phases 9 to 15 are mirror images of stored phases 7 down to 1, with the tap order reversed. Each output phase is packed into three 32-bit words, and those words go to three sub-banks spaced 0x40 bytes apart.

A single start pulse launches the sequence. The block samples the bank base address and the layout mode at that pulse. Two layouts are supported. In the 7-tap layout all taps are packed. In the 5-tap layout only taps 1 to 5 are used, and they shift down into the first five slots. The block reads one whole stored phase per cycle through a combinational read port. It issues one register write per clock whenever the write bus is ready. After the 48th write it raises a one-cycle done pulse.

The FSM has three states:
- `ST_IDLE` waits for `start` and takes the transition idle-to-run.
- `ST_RUN` issues writes. A stalled write holds in place. The accepted 48th write takes the transition run-to-finish.
- `ST_FIN` raises `done` and takes the transition finish-to-idle.

Top module: `coef_mirror_packer`

## Requirements
- R1: After reset, and while idle, `wr_en` and `done` are 0 and no write is issued.
- R2: One start produces exactly 48 accepted writes. They run in phase order 0..15 and, within a phase, in word order 0, 1, 2. Word w of phase p goes to address base + 0x40*w + 4*p.
- R3: The table row holds tap t in bits [12t+11:12t]. In 7-tap mode (`five_tap`=0), slot j holds tap j, and the three words are:
  - word 0 = s0<<16 | s1<<4 | s2[11:8]
  - word 1 = s2[7:0]<<20 | s3<<8 | s4[11:4]
  - word 2 = s4[3:0]<<24 | s5<<12 | s6
  Taps are copied as raw 12-bit two's-complement patterns.
- R4: Output phases 0..8 read stored phase p. Output phases 9..15 read stored phase 16-p and reverse the taps: in 7-tap mode slot j holds tap 6-j. `rd_phase` never exceeds 8.
- R5: In 5-tap mode (`five_tap`=1):
  - Slots 0..4 hold taps 1..5 for direct phases, and taps 5..1 for mirrored phases.
  - Slots 5 and 6 are 0, so word 2 carries only the low nibble of slot 4 at bit 24.
  - Taps 0 and 6 of the table have no effect.
- R6: `done` is high for exactly one cycle. That cycle immediately follows the cycle in which the 48th write was accepted, and `wr_en` is 0 during it.
- R7: While `wr_en`=1 and `wr_ready`=0, the next cycle keeps `wr_en`=1 with the same address and data.
- R8: A `start` pulse during a sequence is ignored. The base address and mode are sampled at the accepted start, so later changes to them do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a sequence (taken only when idle) |
| five_tap | input | 1 | 1 selects the 5-tap layout, 0 the 7-tap layout |
| base_addr | input | 12 | Byte address of the bank's first word |
| rd_phase | output | 4 | Stored phase being read from the source table |
| rd_row | input | 84 | All 7 taps of `rd_phase`, tap t in bits [12t+11:12t] |
| wr_ready | input | 1 | Write bus accepts the presented write this cycle |
| wr_en | output | 1 | Write request |
| wr_addr | output | 12 | Write byte address |
| wr_data | output | 32 | Packed write data |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The hardest situations to reach from the ports are a stall that lands exactly on the mirror boundary (phase 8 to 9) or on the final write, and a start arriving mid-sequence together with new base and mode values. The bench repeats every bank base and both modes under two ready patterns. One pattern is always ready. The other is a period-3 gap whose offset shifts from run to run, so stalls fall on every word position and on both sides of the boundary. A dedicated run then changes `base_addr` and `five_tap` and pulses `start` mid-way, and checks that every write still matches the original configuration.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } cpk_state_t;

    localparam int CPK_WORDS = 3;

endpackage

// File: rtl/cpk_phase_map.sv
module cpk_phase_map #(
    parameter int PHASES = 16,
    localparam int STORED = PHASES / 2 + 1,
    localparam int PH_W   = $clog2(PHASES),
    localparam int SPH_W  = $clog2(STORED)
) (
    input  logic [PH_W-1:0]  out_phase,
    output logic [SPH_W-1:0] src_phase,
    output logic             mirrored
);

    logic [PH_W:0] reflected;

    always_comb begin
        reflected = (PH_W + 1)'(PHASES) - {1'b0, out_phase};
        if (int'(out_phase) < STORED) begin
            mirrored  = 1'b0;
            src_phase = SPH_W'(out_phase);
        end else begin
            mirrored  = 1'b1;
            src_phase = SPH_W'(reflected);
        end
    end

endmodule

// File: rtl/cpk_slot_pack.sv
module cpk_slot_pack #(
    parameter int COEF_W = 12,
    parameter int TAPS   = 7,
    parameter int DATA_W = 32,
    localparam int STREAM_W = COEF_W * TAPS,
    localparam int SEG_W    = STREAM_W / cpk_pkg::CPK_WORDS
) (
    input  logic [STREAM_W-1:0] row,
    input  logic                mirrored,
    input  logic                five_tap,
    input  logic [1:0]          word_sel,
    output logic [DATA_W-1:0]   data
);

    logic [COEF_W-1:0]   coef [TAPS];
    logic [COEF_W-1:0]   slot [TAPS];
    logic [STREAM_W-1:0] stream;
    logic [SEG_W-1:0]    seg;

    for (genvar t = 0; t < TAPS; t++) begin : g_unpack
        assign coef[t] = row[t*COEF_W +: COEF_W];
    end

    for (genvar j = 0; j < TAPS; j++) begin : g_slot
        logic [COEF_W-1:0] full_pick;
        logic [COEF_W-1:0] short_pick;
        assign full_pick = mirrored ? coef[TAPS-1-j] : coef[j];
        if (j < TAPS - 2) begin : g_live
            assign short_pick = mirrored ? coef[TAPS-2-j] : coef[j+1];
        end else begin : g_dead
            assign short_pick = '0;
        end
        assign slot[j] = five_tap ? short_pick : full_pick;
    end

    always_comb begin
        stream = '0;
        for (int j = 0; j < TAPS; j++) begin
            stream[STREAM_W-1-j*COEF_W -: COEF_W] = slot[j];
        end
    end

    always_comb begin
        case (word_sel)
            2'd0:    seg = stream[STREAM_W-1 -: SEG_W];
            2'd1:    seg = stream[STREAM_W-1-SEG_W -: SEG_W];
            2'd2:    seg = stream[STREAM_W-1-2*SEG_W -: SEG_W];
            default: seg = '0;
        endcase
        data = DATA_W'(seg);
    end

endmodule

// File: rtl/cpk_addr_gen.sv
module cpk_addr_gen #(
    parameter int ADDR_W = 12,
    parameter int PHASES = 16,
    parameter int DATA_W = 32,
    localparam int PH_W        = $clog2(PHASES),
    localparam int BYTES       = DATA_W / 8,
    localparam int BANK_STRIDE = PHASES * BYTES
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [PH_W-1:0]   phase,
    input  logic [1:0]        word_sel,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] bank_off;
    logic [ADDR_W-1:0] phase_off;

    always_comb begin
        bank_off  = ADDR_W'(int'(word_sel) * BANK_STRIDE);
        phase_off = ADDR_W'(int'(phase) * BYTES);
        addr      = base + bank_off + phase_off;
    end

endmodule

// File: rtl/coef_mirror_packer.sv
module coef_mirror_packer
    import cpk_pkg::*;
#(
    parameter int COEF_W = 12,
    parameter int TAPS   = 7,
    parameter int PHASES = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int STORED   = PHASES / 2 + 1,
    localparam int PH_W     = $clog2(PHASES),
    localparam int SPH_W    = $clog2(STORED),
    localparam int STREAM_W = COEF_W * TAPS,
    localparam int TOTAL    = PHASES * CPK_WORDS,
    localparam int CNT_W    = $clog2(TOTAL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                five_tap,
    input  logic [ADDR_W-1:0]   base_addr,
    output logic [SPH_W-1:0]    rd_phase,
    input  logic [STREAM_W-1:0] rd_row,
    input  logic                wr_ready,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                done
);

    cpk_state_t        state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [1:0]        word_q;
    logic [ADDR_W-1:0] base_q;
    logic              mode_q;
    logic              mirrored;
    logic              accept;
    logic              last_word;

    assign accept    = wr_en && wr_ready;
    assign last_word = (int'(phase_q) == PHASES - 1) && (int'(word_q) == CPK_WORDS - 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: idle-to-run, run-to-finish, finish-to-idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)              state_d = ST_RUN;
            ST_RUN:  if (accept && last_word) state_d = ST_FIN;
            ST_FIN:                          state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Sequence counters and sampled configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            word_q  <= '0;
            base_q  <= '0;
            mode_q  <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            phase_q <= '0;
            word_q  <= '0;
            base_q  <= base_addr;
            mode_q  <= five_tap;
        end else if (accept) begin
            if (int'(word_q) == CPK_WORDS - 1) begin
                word_q  <= '0;
                phase_q <= phase_q + 1'b1;
            end else begin
                word_q <= word_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        wr_en = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  wr_en = 1'b1;
            ST_FIN:  done  = 1'b1;
            default: ;
        endcase
    end

    cpk_phase_map #(.PHASES(PHASES)) u_map (
        .out_phase (phase_q),
        .src_phase (rd_phase),
        .mirrored  (mirrored)
    );

    cpk_slot_pack #(.COEF_W(COEF_W), .TAPS(TAPS), .DATA_W(DATA_W)) u_pack (
        .row      (rd_row),
        .mirrored (mirrored),
        .five_tap (mode_q),
        .word_sel (word_q),
        .data     (wr_data)
    );

    cpk_addr_gen #(.ADDR_W(ADDR_W), .PHASES(PHASES), .DATA_W(DATA_W)) u_addr (
        .base     (base_q),
        .phase    (phase_q),
        .word_sel (word_q),
        .addr     (wr_addr)
    );

    // Checker support: writes accepted since the last accepted start
    logic [CNT_W-1:0] acc_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           acc_cnt <= '0;
        else if (state_q == ST_IDLE && start) acc_cnt <= '0;
        else if (accept)                      acc_cnt <= acc_cnt + 1'b1;
    end

    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> !wr_en);

    a_r4_src_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(rd_phase) < STORED));

    a_r6_done_after_all: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(acc_cnt) == TOTAL) && !wr_en);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> wr_en && $stable(wr_addr));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && start) |=> $stable(base_q) && $stable(mode_q));

endmodule

// File: tb/coef_mirror_packer_test.sv
module coef_mirror_packer_test;

    localparam int CLK_PERIOD = 10;
    localparam int PHASES = 16;
    localparam int STORED = 9;
    localparam int TOTAL  = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        five_tap = 1'b0;
    logic [11:0] base_addr = '0;
    logic [3:0]  rd_phase;
    logic [83:0] rd_row;
    logic        wr_ready = 1'b0;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic        done;

    int checks = 0;
    int errors = 0;
    int seed = 0;
    int k = 0;
    logic [11:0] run_base = '0;
    bit run_ft = 1'b0;
    bit done_due = 1'b0;
    bit after_done = 1'b0;
    bit stall_pending = 1'b0;
    logic [11:0] stall_addr;
    logic [31:0] stall_data;
    int cyc = 0;
    int roff = 0;
    bit rdy_mode = 1'b0;

    coef_mirror_packer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .five_tap(five_tap),
        .base_addr(base_addr), .rd_phase(rd_phase), .rd_row(rd_row),
        .wr_ready(wr_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] tbl(int sd, int ph, int t);
        return 12'((ph * 7 + t) * 613 + sd * 1877 + 5);
    endfunction

    always_comb begin
        for (int t = 0; t < 7; t++) rd_row[t*12 +: 12] = tbl(seed, int'(rd_phase), t);
    end

    function automatic logic [31:0] slot(int sd, bit ft, int p, int j);
        int sp;
        bit mir;
        mir = (p >= STORED);
        sp  = mir ? PHASES - p : p;
        if (ft) begin
            if (j >= 5) return 32'd0;
            return {20'd0, mir ? tbl(sd, sp, 5 - j) : tbl(sd, sp, j + 1)};
        end
        return {20'd0, mir ? tbl(sd, sp, 6 - j) : tbl(sd, sp, j)};
    endfunction

    function automatic logic [31:0] exp_data(int sd, bit ft, int p, int w);
        logic [31:0] s [7];
        for (int j = 0; j < 7; j++) s[j] = slot(sd, ft, p, j);
        case (w)
            0: return (s[0] << 16) | (s[1] << 4) | (s[2] >> 8);
            1: return ((s[2] & 32'hFF) << 20) | (s[3] << 8) | (s[4] >> 4);
            default: return ((s[4] & 32'hF) << 24) | (s[5] << 12) | s[6];
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Ready driver
    always @(posedge clk) begin
        cyc++;
        #1;
        wr_ready = rdy_mode ? (((cyc + roff) % 3) != 0) : 1'b1;
    end

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_pending) begin
                check(wr_en && wr_addr == stall_addr && wr_data == stall_data,
                      "R7", "stall hold addr", {20'd0, wr_addr}, {20'd0, stall_addr});
                stall_pending = 1'b0;
            end
            if (done_due) begin
                check(done == 1'b1, "R6", "done after last write", {31'd0, done}, 32'd1);
                check(wr_en == 1'b0, "R6", "wr_en during done", {31'd0, wr_en}, 32'd0);
                done_due = 1'b0;
                after_done = 1'b1;
            end else if (after_done) begin
                check(done == 1'b0, "R6", "done single cycle", {31'd0, done}, 32'd0);
                after_done = 1'b0;
            end else if (done) begin
                check(1'b0, "R6", "unexpected done", 32'd1, 32'd0);
            end
            if (wr_en) begin
                if (!wr_ready) begin
                    stall_pending = 1'b1;
                    stall_addr = wr_addr;
                    stall_data = wr_data;
                end else begin
                    int p;
                    int w;
                    logic [11:0] ea;
                    logic [31:0] ed;
                    check(k < TOTAL, "R2", "write count", k, TOTAL - 1);
                    p  = k / 3;
                    w  = k % 3;
                    ea = run_base + 12'(w * 64) + 12'(p * 4);
                    ed = exp_data(seed, run_ft, p, w);
                    check(wr_addr == ea, "R2", "address", {20'd0, wr_addr}, {20'd0, ea});
                    if (p >= STORED)
                        check(wr_data == ed, "R4", "mirrored data", wr_data, ed);
                    else if (run_ft)
                        check(wr_data == ed, "R5", "five-tap data", wr_data, ed);
                    else
                        check(wr_data == ed, "R3", "seven-tap data", wr_data, ed);
                    k++;
                    if (k == TOTAL) done_due = 1'b1;
                end
            end
        end
    end

    task automatic run(logic [11:0] b, bit ft, int sd, bit disturb);
        int err_before;
        @(posedge clk); #1;
        err_before = errors;
        seed = sd;
        run_base = b;
        run_ft = ft;
        k = 0;
        base_addr = b;
        five_tap = ft;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (disturb) begin
            repeat (10) @(posedge clk);
            #1;
            base_addr = ~b;
            five_tap = ~ft;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (!(k == TOTAL && !done_due && !after_done)) @(posedge clk);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(k == TOTAL, "R2", "no extra writes", k, TOTAL);
        check(!wr_en && !done, "R1", "idle after sequence", {31'd0, wr_en}, 32'd0);
        if (disturb)
            check(errors == err_before, "R8", "start ignored while busy", errors, err_before);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(wr_en == 1'b0 && done == 1'b0, "R1", "reset outputs", {31'd0, wr_en}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(wr_en == 1'b0 && k == 0, "R1", "idle without start", {31'd0, wr_en}, 32'd0);
        begin
            logic [11:0] bases [4];
            int idx;
            bases[0] = 12'h080;
            bases[1] = 12'h140;
            bases[2] = 12'h200;
            bases[3] = 12'h300;
            idx = 0;
            for (int bi = 0; bi < 4; bi++) begin
                for (int ft = 0; ft < 2; ft++) begin
                    for (int rm = 0; rm < 2; rm++) begin
                        rdy_mode = rm[0];
                        roff = idx;
                        run(bases[bi], ft[0], idx + 1, 1'b0);
                        idx++;
                    end
                end
            end
            rdy_mode = 1'b1;
            roff = 1;
            run(12'h140, 1'b1, 77, 1'b1);
            rdy_mode = 1'b0;
            run(12'h200, 1'b0, 91, 1'b1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", k, TOTAL);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule